// File: doc/BRIEF.md
# PHY Interrupt Status Controller

This block gathers up to eight single-cycle PHY event pulses into one 16-bit interrupt register and drives an interrupt pin toward the management host. The register has two halves. The high byte holds an enable for each condition. The low byte holds sticky flags that show which conditions have fired. A host reads the register through the management interface. Each read strobe empties every flag, so after a read the host sees only events that arrived later.

The pin is level based. It is asserted while at least one flag is set and its matching enable is also set. Its polarity comes from one bit of a separate control register, which is written through its own port. Event detection and the serial management protocol sit outside this block. This block sees a read strobe, two write ports and the raw event pulses.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset the enable byte and the status byte are both zero and the polarity is active low, so `irq_reg_o` reads 0x0000 and `irq_pin_o` is 1.
- R2: An event pulse on `event_i[n]` sets status bit n (register bit n) on the next clock edge, whether or not enable n is set.
- R3: A status bit that is set stays set while no read strobe occurs.
- R4: A read strobe on `irq_rd_i` clears every status bit at the clock edge that samples the strobe. During the strobe cycle, `irq_reg_o` still shows the value before the clear.
- R5: An event that arrives in the same cycle as a read strobe leaves its status bit set after that edge.
- R6: A write strobe on `irq_wr_i` loads `irq_wdata_i[15:8]` into the enable byte (register bits 15:8). The written low byte has no effect on the status bits.
- R7: The pin is active exactly when some status bit n and enable bit n are both set. Status bits whose enable is clear never activate the pin.
- R8: Bit 9 of the control register, written through `ctrl_wr_i`/`ctrl_wdata_i`, selects the pin polarity: 1 means active high and 0 means active low. The other control bits have no effect.
- R9: If a status bit is already set, writing its enable bit activates the pin right after the write edge, with no new event needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 8 | Single-cycle event pulses, one per condition |
| irq_rd_i | input | 1 | Read strobe of the interrupt register; clears status |
| irq_wr_i | input | 1 | Write strobe of the interrupt register |
| irq_wdata_i | input | 16 | Write data; only bits 15:8 are used |
| ctrl_wr_i | input | 1 | Write strobe of the control register |
| ctrl_wdata_i | input | 16 | Control write data; bit 9 selects polarity |
| irq_reg_o | output | 16 | Interrupt register: enables in 15:8, status in 7:0 |
| irq_pin_o | output | 1 | Interrupt pin, polarity per control bit 9 |

## Verification
Directed cases cover the following:
- events on disabled conditions, which separate flag capture from pin activation;
- a late enable on an already-set flag, which shows that the pin is level based and not edge based;
- a read that coincides with an event, which shows whether clear or set wins;
- writes whose low byte is all ones, which show whether data leaks into the status flags.

Random cycles then mix event bursts, reads, enable writes and polarity flips. This catches wrong interactions between clearing, masking and polarity that no single directed case reaches.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  typedef enum logic {
    POL_ACT_LOW  = 1'b0,
    POL_ACT_HIGH = 1'b1
  } irq_pol_e;

  localparam int unsigned IRQ_DATA_W  = 16;
  localparam int unsigned IRQ_POL_BIT = 9;
endpackage

// File: rtl/phy_irq_status.sv
module phy_irq_status #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    logic flag_q;
    // set beats clear so a colliding event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q <= 1'b0;
      else if (event_i[g]) flag_q <= 1'b1;
      else if (clr_i)      flag_q <= 1'b0;
    end
    assign status_o[g] = flag_q;
  end
endmodule

// File: rtl/phy_irq_cfg.sv
module phy_irq_cfg
  import phy_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               pol_wr_i,
  input  logic               pol_wdata_i,
  output logic [NUM_SRC-1:0] enable_o,
  output irq_pol_e           pol_o
);
  logic [NUM_SRC-1:0] en_q;
  irq_pol_e           pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= POL_ACT_LOW;
    else if (pol_wr_i) pol_q <= irq_pol_e'(pol_wdata_i);
  end

  assign enable_o = en_q;
  assign pol_o    = pol_q;
endmodule

// File: rtl/phy_irq_out.sv
module phy_irq_out
  import phy_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  irq_pol_e           pol_i,
  output logic               pin_o
);
  logic pending;
  assign pending = |(status_i & enable_i);
  assign pin_o   = (pol_i == POL_ACT_HIGH) ? pending : ~pending;
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = IRQ_DATA_W,
  parameter int unsigned POL_BIT = IRQ_POL_BIT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W/2-1:0] event_i,
  input  logic                irq_rd_i,
  input  logic                irq_wr_i,
  input  logic [DATA_W-1:0]   irq_wdata_i,
  input  logic                ctrl_wr_i,
  input  logic [DATA_W-1:0]   ctrl_wdata_i,
  output logic [DATA_W-1:0]   irq_reg_o,
  output logic                irq_pin_o
);
  localparam int unsigned NUM_SRC = DATA_W / 2;

  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable;
  irq_pol_e           pol;
  logic               unused_wdata;

  assign unused_wdata = ^{irq_wdata_i[NUM_SRC-1:0], ctrl_wdata_i};

  phy_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (event_i),
    .clr_i    (irq_rd_i),
    .status_o (status)
  );

  phy_irq_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_wr_i     (irq_wr_i),
    .en_wdata_i  (irq_wdata_i[DATA_W-1:NUM_SRC]),
    .pol_wr_i    (ctrl_wr_i),
    .pol_wdata_i (ctrl_wdata_i[POL_BIT]),
    .enable_o    (enable),
    .pol_o       (pol)
  );

  phy_irq_out #(.NUM_SRC(NUM_SRC)) u_out (
    .status_i (status),
    .enable_i (enable),
    .pol_i    (pol),
    .pin_o    (irq_pin_o)
  );

  assign irq_reg_o = {enable, status};
endmodule

// File: rtl/phy_irq_ctrl_chk.sv
module phy_irq_ctrl_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned POL_BIT = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DATA_W/2-1:0] event_i,
  input logic                irq_rd_i,
  input logic                irq_wr_i,
  input logic [DATA_W-1:0]   irq_wdata_i,
  input logic                ctrl_wr_i,
  input logic [DATA_W-1:0]   ctrl_wdata_i,
  input logic [DATA_W-1:0]   irq_reg_o,
  input logic                irq_pin_o
);
  localparam int unsigned N = DATA_W / 2;

  logic pol_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pol_seen_q <= 1'b0;
    else if (ctrl_wr_i) pol_seen_q <= ctrl_wdata_i[POL_BIT];
  end

  logic pend;
  assign pend = |(irq_reg_o[DATA_W-1:N] & irq_reg_o[N-1:0]);

  // R2
  ev_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((irq_reg_o[N-1:0] & $past(event_i)) == $past(event_i)));

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_rd_i |=> ((irq_reg_o[N-1:0] & $past(irq_reg_o[N-1:0])) == $past(irq_reg_o[N-1:0])));

  // R4
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rd_i |=> (irq_reg_o[N-1:0] == $past(event_i)));

  // R6
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wr_i |=> (irq_reg_o[DATA_W-1:N] == $past(irq_wdata_i[DATA_W-1:N])));

  // R6
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_wr_i |=> $stable(irq_reg_o[DATA_W-1:N]));

  // R7
  pin_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pin_o == (pol_seen_q ? pend : ~pend));

  // R8
  pol_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !irq_wr_i && !irq_rd_i && !(|event_i) &&
     (ctrl_wdata_i[POL_BIT] != pol_seen_q)) |=> (irq_pin_o != $past(irq_pin_o)));
endmodule

bind phy_irq_ctrl phy_irq_ctrl_chk #(.DATA_W(DATA_W), .POL_BIT(POL_BIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .event_i      (event_i),
  .irq_rd_i     (irq_rd_i),
  .irq_wr_i     (irq_wr_i),
  .irq_wdata_i  (irq_wdata_i),
  .ctrl_wr_i    (ctrl_wr_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .irq_reg_o    (irq_reg_o),
  .irq_pin_o    (irq_pin_o)
);

// File: tb/phy_irq_ctrl_tb.sv
`timescale 1ns/1ps
module phy_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  event_i = '0;
  logic        irq_rd_i = 1'b0;
  logic        irq_wr_i = 1'b0;
  logic [15:0] irq_wdata_i = '0;
  logic        ctrl_wr_i = 1'b0;
  logic [15:0] ctrl_wdata_i = '0;
  logic [15:0] irq_reg_o;
  logic        irq_pin_o;

  int unsigned vectors = 0;
  int unsigned errors  = 0;
  bit          done    = 1'b0;

  logic [7:0] m_en, m_st;
  logic       m_pol;

  always #2.5 clk_i = ~clk_i;

  phy_irq_ctrl u_dut (
    .clk_i, .rst_ni, .event_i, .irq_rd_i, .irq_wr_i, .irq_wdata_i,
    .ctrl_wr_i, .ctrl_wdata_i, .irq_reg_o, .irq_pin_o
  );

  function automatic logic [7:0] nxt_status(logic [7:0] st, logic [7:0] ev, logic rd);
    return (rd ? 8'h00 : st) | ev;
  endfunction

  function automatic logic exp_pin(logic [7:0] st, logic [7:0] en, logic pol);
    logic act;
    act = |(st & en);
    return pol ? act : ~act;
  endfunction

  task automatic chk(string tag);
    vectors++;
    if (irq_reg_o !== {m_en, m_st}) begin
      errors++;
      $display("FAIL %s reg: got %h exp %h", tag, irq_reg_o, {m_en, m_st});
    end
    vectors++;
    if (irq_pin_o !== exp_pin(m_st, m_en, m_pol)) begin
      errors++;
      $display("FAIL %s pin: got %b exp %b", tag, irq_pin_o, exp_pin(m_st, m_en, m_pol));
    end
  endtask

  task automatic step(logic [7:0] ev, logic rd, logic wr, logic [15:0] wd,
                      logic cwr, logic [15:0] cwd, string tag);
    event_i = ev; irq_rd_i = rd; irq_wr_i = wr; irq_wdata_i = wd;
    ctrl_wr_i = cwr; ctrl_wdata_i = cwd;
    @(posedge clk_i);
    #1;
    m_st = nxt_status(m_st, ev, rd);
    if (wr)  m_en  = wd[15:8];
    if (cwr) m_pol = cwd[9];
    event_i = '0; irq_rd_i = 0; irq_wr_i = 0; ctrl_wr_i = 0;
    @(negedge clk_i);
    chk(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = '0; m_st = '0; m_pol = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset");

    step(8'h08, 0, 0, 16'h0, 0, 16'h0, "R2 disabled event captured");
    step(8'h00, 0, 0, 16'h0, 0, 16'h0, "R7 disabled flag keeps pin idle");
    step(8'h00, 0, 1, 16'h0800, 0, 16'h0, "R9 late enable asserts pin");
    step(8'h00, 0, 0, 16'h0, 1, 16'h0200, "R8 active high");
    step(8'h00, 0, 0, 16'h0, 1, 16'hFDFF, "R8 other ctrl bits ignored");
    step(8'h00, 0, 0, 16'h0, 0, 16'h0, "R3 flag sticky");
    step(8'h00, 1, 0, 16'h0, 0, 16'h0, "R4 read clears status");
    step(8'h20, 1, 0, 16'h0, 0, 16'h0, "R5 event with read kept");
    step(8'h00, 0, 1, 16'hA5FF, 0, 16'h0, "R6 low byte write ignored");
    step(8'h5A, 0, 1, 16'h00FF, 0, 16'h0, "R6 enable cleared while events land");
    step(8'h00, 0, 0, 16'h0, 0, 16'h0, "R7 all flags masked");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  ev;
      logic        rd, wr, cwr;
      logic [15:0] wd, cwd;
      ev  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      rd  = (($urandom % 6) == 0);
      wr  = (($urandom % 8) == 0);
      cwr = (($urandom % 10) == 0);
      wd  = 16'($urandom);
      cwd = 16'($urandom);
      step(ev, rd, wr, wd, cwr, cwd, "R7 random mix");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule